// File: doc/BRIEF.md
# Masked-Address I2C Target with Echo Buffer

This block is an I2C target with 7-bit addressing. It samples the bus clock and data lines through a synchroniser in the system clock domain and drives both lines only as open-drain pull-down enables. It decodes its own address from a programmable 7-bit address and a per-bit mask. The address field value zero is reserved for general call, which is off unless enabled.

Bytes that a controller writes are kept in an internal buffer. A controller read first gets back the address byte that selected the target. After that it gets the stored bytes in the order they arrived, and once those run out it gets zero bytes. After every byte it accepts, the target holds the clock low for a fixed number of cycles while it handles the byte. A status vector and a one-cycle byte pulse show which transfer phase the target is in.

Top module: `i2c_echo_target`

## Requirements
- R1: The address byte carries the 7-bit address in bits 7:1 and the direction in bit 0, where 1 means read. For a nonzero address field, the target acknowledges when every address bit whose mask bit is 1 equals the matching bit of `own_addr_i`. Bits whose mask bit is 0 are ignored. Any other address is not acknowledged: SDA is never pulled, and the target waits for the next START.
- R2: An address field of zero is acknowledged only while `gc_en_i` is 1.
- R3: Each acknowledged received byte, and each transmitted byte that the controller acknowledges, makes `scl_pull_o` high for exactly HOLD_CYC cycles. The first of those cycles follows the detected falling clock edge that ends the byte. `scl_pull_o` is never high at any other time.
- R4: While a byte is being held, the status bits {`st_start_o`, `st_data_o`, `st_read_o`, `st_full_o`} read as follows: 1001 after a write address, 1101 after a write data byte, 1011 after a read address, and 1110 before each read data byte after the first.
- R5: When the controller does not acknowledge a transmitted byte, the target releases SDA, returns to idle and does not stretch the clock. `st_data_o` and `st_read_o` both stay 1.
- R6: A write-address match resets the write index to 0. Each data byte that follows is stored at the index, and the index then advances.
- R7: After a read-address match, the first byte sent is the received address byte, and the read index resets to 0. Each later byte is the stored byte at the read index while that index is below the write count, and the index then advances. Once the stored bytes are used up, 0x00 is sent.
- R8: The buffer holds DEPTH bytes. Data bytes beyond DEPTH are acknowledged but discarded, and the write count stops at DEPTH.
- R9: A STOP (SDA rising while SCL is high) clears `addr_o` to 0x00, sets `st_stop_o` and clears `st_start_o`. A START (SDA falling while SCL is high) sets `st_start_o` and clears `st_stop_o`.
- R10: A repeated START in the middle of a transfer restarts address reception. A read then addressed in the same transfer works as in R7.
- R11: `byte_done_o` pulses for one cycle, in the first held cycle of each byte described in R3, and at no other time.
- R12: After reset, both pull enables are 0, every status flag is 0, `byte_done_o` is 0 and `addr_o` is 0x00.
- R13: `st_full_o` rises when a received byte is held and falls in the cycle that releases SCL. It stays 0 for transmitted bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the wire |
| sda_i | input | 1 | Bus data line as seen on the wire |
| scl_pull_o | output | 1 | 1 pulls the clock line low (stretching) |
| sda_pull_o | output | 1 | 1 pulls the data line low |
| own_addr_i | input | 7 | Target address |
| addr_mask_i | input | 7 | Per-bit compare enable, 1 = must match |
| gc_en_i | input | 1 | Accept the all-zero address field |
| st_start_o | output | 1 | START seen since the last STOP |
| st_stop_o | output | 1 | STOP seen last |
| st_data_o | output | 1 | Last byte was data (0 = address) |
| st_read_o | output | 1 | Current transfer is a read |
| st_full_o | output | 1 | Received byte waiting to be handled |
| byte_done_o | output | 1 | One-cycle pulse per handled byte |
| addr_o | output | 8 | Address byte of the current transfer |

## Verification
The assertions check the stretch window every cycle: it begins with a byte pulse, it never exceeds HOLD_CYC cycles, and the full flag is down when it ends. They also check that START and STOP flags exclude each other and that STOP leaves the stored address at zero. The bench scenarios are needed for the rest, because they depend on what a controller sends. That covers mask decoding, the general-call gate, the echo of the address followed by buffered bytes and zero padding, discarding past the buffer depth, the repeated START, and the no-stretch return to idle after a controller NACK.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_RX    = 3'd1,
    PH_HOLD  = 3'd2,
    PH_ACK   = 3'd3,
    PH_TX    = 3'd4,
    PH_TXACK = 3'd5
  } phase_e;
endpackage

// File: rtl/i2ct_sync.sv
module i2ct_sync #(
  parameter int N      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '1;
      else         chain_q <= {chain_q[STAGES-2:0], d_i[g]};
    end
    assign q_o[g] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/i2ct_cond.sv
module i2ct_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s_i;
      sda_q <= sda_s_i;
    end
  end

  assign scl_rise_o = scl_s_i & ~scl_q;
  assign scl_fall_o = ~scl_s_i & scl_q;
  // data edges while the clock stays high mark bus conditions
  assign start_o    = scl_s_i & scl_q & sda_q & ~sda_s_i;
  assign stop_o     = scl_s_i & scl_q & ~sda_q & sda_s_i;
endmodule

// File: rtl/i2ct_match.sv
module i2ct_match (
  input  logic [7:0] addr_byte_i,
  input  logic [6:0] own_i,
  input  logic [6:0] mask_i,
  input  logic       gc_en_i,
  output logic       hit_o
);
  logic [6:0] field;
  assign field = addr_byte_i[7:1];

  always_comb begin
    if (field == 7'd0) hit_o = gc_en_i;
    else               hit_o = (((field ^ own_i) & mask_i) == 7'd0);
  end
endmodule

// File: rtl/i2ct_store.sv
module i2ct_store #(
  parameter int DEPTH = 64
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_clr_i,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  input  logic       rd_clr_i,
  input  logic       rd_adv_i,
  output logic [7:0] rd_data_o
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = $clog2(DEPTH);

  logic [7:0]    mem [DEPTH];
  logic [CW-1:0] wr_cnt_q, rd_idx_q;
  logic          room, avail;

  assign room  = (wr_cnt_q < CW'(DEPTH));
  assign avail = (rd_idx_q < wr_cnt_q);

  always_ff @(posedge clk_i) begin
    if (wr_en_i && room) mem[wr_cnt_q[IW-1:0]] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_cnt_q <= '0;
      rd_idx_q <= '0;
    end else begin
      if (wr_clr_i)             wr_cnt_q <= '0;
      else if (wr_en_i && room) wr_cnt_q <= wr_cnt_q + CW'(1);
      if (rd_clr_i)             rd_idx_q <= '0;
      else if (rd_adv_i && avail) rd_idx_q <= rd_idx_q + CW'(1);
    end
  end

  assign rd_data_o = avail ? mem[rd_idx_q[IW-1:0]] : 8'h00;
endmodule

// File: rtl/i2c_echo_target.sv
module i2c_echo_target #(
  parameter int DEPTH       = 64,
  parameter int HOLD_CYC    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_pull_o,
  output logic       sda_pull_o,
  input  logic [6:0] own_addr_i,
  input  logic [6:0] addr_mask_i,
  input  logic       gc_en_i,
  output logic       st_start_o,
  output logic       st_stop_o,
  output logic       st_data_o,
  output logic       st_read_o,
  output logic       st_full_o,
  output logic       byte_done_o,
  output logic [7:0] addr_o
);
  import i2ct_pkg::*;

  localparam int HW = $clog2(HOLD_CYC + 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  // line sampling and condition detection
  logic [1:0] line_s;
  logic       scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  i2ct_sync #(.N(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_n), .d_i({scl_i, sda_i}), .q_o(line_s)
  );
  assign scl_s = line_s[1];
  assign sda_s = line_s[0];

  i2ct_cond u_cond (
    .clk_i(clk_i), .rst_ni(rst_n), .scl_s_i(scl_s), .sda_s_i(sda_s),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  // state
  phase_e        phase_q, phase_d, nxt_q, nxt_d;
  logic [3:0]    bitcnt_q, bitcnt_d;
  logic [7:0]    shreg_q, shreg_d, addr_q, addr_d;
  logic [HW-1:0] hcnt_q, hcnt_d;
  logic          is_addr_q, is_addr_d, mack_q, mack_d, sda_drv_q, sda_drv_d;
  logic          start_q, start_d, stop_q, stop_d, da_q, da_d, rw_q, rw_d;
  logic          bf_q, bf_d, done_q, done_d;

  logic       hit, wr_clr, wr_en, rd_clr, rd_adv;
  logic [7:0] rd_data;

  i2ct_match u_match (
    .addr_byte_i(shreg_q), .own_i(own_addr_i), .mask_i(addr_mask_i),
    .gc_en_i(gc_en_i), .hit_o(hit)
  );

  i2ct_store #(.DEPTH(DEPTH)) u_store (
    .clk_i(clk_i), .rst_ni(rst_n), .wr_clr_i(wr_clr), .wr_en_i(wr_en),
    .wr_data_i(shreg_q), .rd_clr_i(rd_clr), .rd_adv_i(rd_adv),
    .rd_data_o(rd_data)
  );

  // next-state logic
  always_comb begin
    phase_d   = phase_q;
    nxt_d     = nxt_q;
    bitcnt_d  = bitcnt_q;
    shreg_d   = shreg_q;
    addr_d    = addr_q;
    hcnt_d    = hcnt_q;
    is_addr_d = is_addr_q;
    mack_d    = mack_q;
    sda_drv_d = sda_drv_q;
    start_d   = start_q;
    stop_d    = stop_q;
    da_d      = da_q;
    rw_d      = rw_q;
    bf_d      = bf_q;
    done_d    = 1'b0;
    wr_clr    = 1'b0;
    wr_en     = 1'b0;
    rd_clr    = 1'b0;
    rd_adv    = 1'b0;

    if (start_det) begin
      phase_d   = PH_RX;
      bitcnt_d  = 4'd0;
      is_addr_d = 1'b1;
      sda_drv_d = 1'b0;
      start_d   = 1'b1;
      stop_d    = 1'b0;
    end else if (stop_det) begin
      phase_d   = PH_IDLE;
      sda_drv_d = 1'b0;
      addr_d    = 8'h00;
      stop_d    = 1'b1;
      start_d   = 1'b0;
    end else begin
      unique case (phase_q)
        PH_RX: begin
          if (scl_rise) begin
            shreg_d  = {shreg_q[6:0], sda_s};
            bitcnt_d = bitcnt_q + 4'd1;
          end else if (scl_fall && bitcnt_q == 4'd8) begin
            if (is_addr_q) begin
              if (hit) begin
                addr_d    = shreg_q;
                rw_d      = shreg_q[0];
                da_d      = 1'b0;
                bf_d      = 1'b1;
                done_d    = 1'b1;
                phase_d   = PH_HOLD;
                nxt_d     = PH_ACK;
                hcnt_d    = '0;
                sda_drv_d = 1'b1;
                is_addr_d = 1'b0;
                rd_clr    = shreg_q[0];
                wr_clr    = ~shreg_q[0];
              end else begin
                phase_d = PH_IDLE;
              end
            end else begin
              da_d      = 1'b1;
              bf_d      = 1'b1;
              done_d    = 1'b1;
              wr_en     = 1'b1;
              phase_d   = PH_HOLD;
              nxt_d     = PH_ACK;
              hcnt_d    = '0;
              sda_drv_d = 1'b1;
            end
          end
        end
        PH_HOLD: begin
          if (hcnt_q == HW'(HOLD_CYC - 1)) begin
            phase_d = nxt_q;
            bf_d    = 1'b0;
          end else begin
            hcnt_d = hcnt_q + HW'(1);
          end
        end
        PH_ACK: begin
          if (scl_fall) begin
            bitcnt_d = 4'd0;
            if (rw_q) begin
              phase_d   = PH_TX;
              sda_drv_d = ~shreg_q[7];
            end else begin
              phase_d   = PH_RX;
              sda_drv_d = 1'b0;
            end
          end
        end
        PH_TX: begin
          if (scl_fall) begin
            if (bitcnt_q == 4'd7) begin
              sda_drv_d = 1'b0;
              phase_d   = PH_TXACK;
            end else begin
              shreg_d   = {shreg_q[6:0], 1'b0};
              sda_drv_d = ~shreg_q[6];
              bitcnt_d  = bitcnt_q + 4'd1;
            end
          end
        end
        PH_TXACK: begin
          if (scl_rise) begin
            mack_d = sda_s;
          end else if (scl_fall) begin
            if (!mack_q) begin
              shreg_d   = rd_data;
              rd_adv    = 1'b1;
              da_d      = 1'b1;
              done_d    = 1'b1;
              phase_d   = PH_HOLD;
              nxt_d     = PH_TX;
              hcnt_d    = '0;
              bitcnt_d  = 4'd0;
              sda_drv_d = ~rd_data[7];
            end else begin
              phase_d   = PH_IDLE;
              sda_drv_d = 1'b0;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      nxt_q     <= PH_IDLE;
      bitcnt_q  <= 4'd0;
      shreg_q   <= 8'h00;
      addr_q    <= 8'h00;
      hcnt_q    <= '0;
      is_addr_q <= 1'b0;
      mack_q    <= 1'b1;
      sda_drv_q <= 1'b0;
      start_q   <= 1'b0;
      stop_q    <= 1'b0;
      da_q      <= 1'b0;
      rw_q      <= 1'b0;
      bf_q      <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      phase_q   <= phase_d;
      nxt_q     <= nxt_d;
      bitcnt_q  <= bitcnt_d;
      shreg_q   <= shreg_d;
      addr_q    <= addr_d;
      hcnt_q    <= hcnt_d;
      is_addr_q <= is_addr_d;
      mack_q    <= mack_d;
      sda_drv_q <= sda_drv_d;
      start_q   <= start_d;
      stop_q    <= stop_d;
      da_q      <= da_d;
      rw_q      <= rw_d;
      bf_q      <= bf_d;
      done_q    <= done_d;
    end
  end

  assign scl_pull_o  = (phase_q == PH_HOLD);
  assign sda_pull_o  = sda_drv_q;
  assign st_start_o  = start_q;
  assign st_stop_o   = stop_q;
  assign st_data_o   = da_q;
  assign st_read_o   = rw_q;
  assign st_full_o   = bf_q;
  assign byte_done_o = done_q;
  assign addr_o      = addr_q;
endmodule

// File: rtl/i2ct_check.sv
module i2ct_check #(
  parameter int HOLD_CYC = 16
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       scl_pull_o,
  input logic       st_start_o,
  input logic       st_stop_o,
  input logic       st_data_o,
  input logic       st_read_o,
  input logic       st_full_o,
  input logic       byte_done_o,
  input logic [7:0] addr_o
);
  localparam int RW = $clog2(HOLD_CYC + 2);

  // number of consecutive earlier cycles with the clock held
  logic [RW-1:0] run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        run_q <= '0;
    else if (!scl_pull_o)               run_q <= '0;
    else if (run_q != RW'(HOLD_CYC + 1)) run_q <= run_q + RW'(1);
  end

  p_stretch_limit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_pull_o |-> (run_q < RW'(HOLD_CYC)));

  p_hold_opens_with_done_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(scl_pull_o) |-> byte_done_o);

  p_done_in_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_done_o |-> scl_pull_o);

  p_done_single_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_done_o |=> !byte_done_o);

  p_done_after_start_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_done_o |-> st_start_o);

  p_full_not_read_data_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_full_o |-> !(st_data_o && st_read_o));

  p_full_down_on_release_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(scl_pull_o) |-> !st_full_o);

  p_stop_clears_addr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(st_stop_o) |-> (addr_o == 8'h00));

  p_start_stop_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(st_start_o && st_stop_o));
endmodule

bind i2c_echo_target i2ct_check #(.HOLD_CYC(HOLD_CYC)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_pull_o(scl_pull_o),
  .st_start_o(st_start_o), .st_stop_o(st_stop_o), .st_data_o(st_data_o),
  .st_read_o(st_read_o), .st_full_o(st_full_o), .byte_done_o(byte_done_o),
  .addr_o(addr_o)
);

// File: tb/sim_i2c_echo_target.sv
module sim_i2c_echo_target;
  localparam int CLK_PERIOD = 10;
  localparam int T          = 8;
  localparam int DEPTH      = 64;
  localparam int HOLD       = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic       m_scl = 1'b0, m_sda = 1'b0;
  logic       scl_pull, sda_pull, scl_bus, sda_bus;
  logic [6:0] own = 7'h50, mask = 7'h7F;
  logic       gc_en = 1'b0;
  logic       st_start, st_stop, st_data, st_read, st_full, done;
  logic [7:0] addr;

  assign scl_bus = !(m_scl || scl_pull);
  assign sda_bus = !(m_sda || sda_pull);

  i2c_echo_target #(.DEPTH(DEPTH), .HOLD_CYC(HOLD), .SYNC_STAGES(2)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_pull_o(scl_pull), .sda_pull_o(sda_pull),
    .own_addr_i(own), .addr_mask_i(mask), .gc_en_i(gc_en),
    .st_start_o(st_start), .st_stop_o(st_stop), .st_data_o(st_data),
    .st_read_o(st_read), .st_full_o(st_full), .byte_done_o(done),
    .addr_o(addr)
  );

  int tests = 0, fails = 0;
  logic [3:0] exp_q[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic wait_scl_high();
    while (!scl_bus) @(posedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b0; wclk(T);
    m_scl = 1'b0; wait_scl_high(); wclk(T);
    m_sda = 1'b1; wclk(T);
    m_scl = 1'b1; wclk(T);
  endtask

  task automatic bus_stop();
    m_sda = 1'b1; wclk(T);
    m_scl = 1'b0; wait_scl_high(); wclk(T);
    m_sda = 1'b0; wclk(T);
  endtask

  task automatic bit_w(input logic b);
    m_sda = !b; wclk(T);
    m_scl = 1'b0; wait_scl_high(); wclk(T);
    m_scl = 1'b1; wclk(T);
  endtask

  task automatic bit_r(output logic b);
    m_sda = 1'b0; wclk(T);
    m_scl = 1'b0; wait_scl_high(); wclk(T / 2);
    b = sda_bus; wclk(T / 2);
    m_scl = 1'b1; wclk(T);
  endtask

  // driver: pushes the status expected at the byte pulse, checks the ACK bit
  task automatic send_byte(input logic [7:0] b, input bit exp_ack,
                           input logic [3:0] st, input string req);
    logic a;
    if (exp_ack) exp_q.push_back(st);
    for (int i = 7; i >= 0; i--) bit_w(b[i]);
    bit_r(a);
    chk((a == 1'b0) == exp_ack, req, int'(a), int'(!exp_ack));
  endtask

  task automatic recv_byte(input logic [7:0] exp, input bit mack, input string req);
    logic [7:0] v;
    logic b;
    for (int i = 7; i >= 0; i--) begin
      bit_r(b);
      v[i] = b;
    end
    if (mack) exp_q.push_back(4'b1110);
    bit_w(!mack);
    chk(v == exp, req, int'(v), int'(exp));
  endtask

  // monitor: pops expected status at each byte pulse, measures stretches
  int run = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (done) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R11 unexpected byte pulse", 1, 0);
        end else begin
          logic [3:0] e;
          e = exp_q.pop_front();
          chk({st_start, st_data, st_read, st_full} == e, "R4 status at byte pulse",
              int'({st_start, st_data, st_read, st_full}), int'(e));
        end
      end
      if (scl_pull) run++;
      else if (run != 0) begin
        chk(run == HOLD, "R3 stretch length", run, HOLD);
        run = 0;
      end
    end
  end

  initial begin : watchdog
    wclk(190000);
    tests++;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    logic nack_stretch;
    wclk(5);
    @(negedge clk);
    chk(!scl_pull && !sda_pull, "R12 pulls after reset", int'({scl_pull, sda_pull}), 0);
    chk({st_start, st_stop, st_data, st_read, st_full, done} == 6'b0,
        "R12 flags after reset", int'({st_start, st_stop, st_data, st_read, st_full, done}), 0);
    chk(addr == 8'h00, "R12 address after reset", int'(addr), 0);
    rst_n = 1'b1;
    wclk(5);

    // write three bytes
    bus_start();
    chk(st_start && !st_stop, "R9 START flags", int'({st_start, st_stop}), 2);
    send_byte(8'hA0, 1'b1, 4'b1001, "R1 write address ack");
    chk(addr == 8'hA0, "R1 stored address", int'(addr), 8'hA0);
    chk(!st_full, "R13 full cleared after release", int'(st_full), 0);
    send_byte(8'h11, 1'b1, 4'b1101, "R6 data ack");
    send_byte(8'h22, 1'b1, 4'b1101, "R6 data ack");
    send_byte(8'h33, 1'b1, 4'b1101, "R6 data ack");
    bus_stop();
    @(negedge clk);
    chk(addr == 8'h00, "R9 STOP clears address", int'(addr), 0);
    chk(st_stop && !st_start, "R9 STOP flags", int'({st_start, st_stop}), 1);

    // read back: echo, buffer, padding, NACK
    bus_start();
    send_byte(8'hA1, 1'b1, 4'b1011, "R7 read address ack");
    recv_byte(8'hA1, 1'b1, "R7 echo of address");
    recv_byte(8'h11, 1'b1, "R7 buffered byte 0");
    recv_byte(8'h22, 1'b1, "R7 buffered byte 1");
    recv_byte(8'h33, 1'b1, "R7 buffered byte 2");
    recv_byte(8'h00, 1'b1, "R7 zero padding");
    recv_byte(8'h00, 1'b0, "R7 zero padding last");
    nack_stretch = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (scl_pull) nack_stretch = 1'b1;
    end
    chk(!nack_stretch, "R5 no stretch after NACK", int'(nack_stretch), 0);
    chk(!sda_pull, "R5 SDA released after NACK", int'(sda_pull), 0);
    chk(st_data && st_read, "R5 data and read flags", int'({st_data, st_read}), 3);
    bus_stop();

    // mask: low two bits don't care
    mask = 7'h7C;
    bus_start();
    send_byte(8'hA6, 1'b1, 4'b1001, "R1 masked bits ignored");
    bus_stop();
    bus_start();
    send_byte(8'hA8, 1'b0, 4'b0000, "R1 compared bit differs");
    chk(!sda_pull, "R1 no pull after miss", int'(sda_pull), 0);
    bus_stop();
    mask = 7'h7F;
    bus_start();
    send_byte(8'hA2, 1'b0, 4'b0000, "R1 full mask miss");
    bus_stop();

    // general call gate
    bus_start();
    send_byte(8'h00, 1'b0, 4'b0000, "R2 zero address disabled");
    bus_stop();
    gc_en = 1'b1;
    bus_start();
    send_byte(8'h00, 1'b1, 4'b1001, "R2 zero address enabled");
    send_byte(8'h5A, 1'b1, 4'b1101, "R2 general call data");
    bus_stop();
    gc_en = 1'b0;

    // overfill the buffer
    bus_start();
    send_byte(8'hA0, 1'b1, 4'b1001, "R8 write address");
    for (int i = 0; i < DEPTH + 2; i++)
      send_byte(8'(i + 1), 1'b1, 4'b1101, "R8 every data byte acked");
    bus_stop();
    bus_start();
    send_byte(8'hA1, 1'b1, 4'b1011, "R8 read address");
    recv_byte(8'hA1, 1'b1, "R8 echo");
    for (int i = 0; i < DEPTH; i++)
      recv_byte(8'(i + 1), 1'b1, "R8 stored byte");
    recv_byte(8'h00, 1'b0, "R8 excess discarded");
    bus_stop();

    // repeated START: write one byte, then read in the same transfer
    bus_start();
    send_byte(8'hA0, 1'b1, 4'b1001, "R10 write address");
    send_byte(8'h77, 1'b1, 4'b1101, "R6 index restarted");
    bus_start();
    chk(addr == 8'hA0, "R10 address kept across repeated START", int'(addr), 8'hA0);
    send_byte(8'hA1, 1'b1, 4'b1011, "R10 read after repeated START");
    recv_byte(8'hA1, 1'b1, "R10 echo");
    recv_byte(8'h77, 1'b1, "R6 only new byte");
    recv_byte(8'h00, 1'b0, "R6 padding after new byte");
    bus_stop();

    wclk(20);
    chk(exp_q.size() == 0, "R11 all expected byte pulses seen", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule